// File: doc/BRIEF.md
# Multiplexed LED Grid Scanner with Dimming

This block drives a common-cathode LED panel one digit (grid) at a time. It reads each digit's segment pattern from a 14-byte display RAM through a read port, lights that digit's grid for one display slot, and lights the segments for a dimmable part of that slot. After the last digit, one key-scan slot follows in which no grid is lit. The display slots and the key-scan slot together make one frame. The block pulses `frame_end` in the last cycle of each frame, and the surrounding logic latches its key inputs on that pulse.

A two-bit mode picks 4, 5, 6 or 7 grids. Three output pins are shared between the grid and segment roles: each carries either a high segment or a high grid, depending on the mode. Each display slot is split into 16 sub-steps of `STEP_CYC` clock cycles. Sub-step 0 and sub-step 15 are always blank, so the segments are dark before the grid enable moves on. A three-bit dimming code sets how many sub-steps are lit. The display-on input gates every output at once. Mode and dimming are taken only at frame boundaries.

Top module: `led_grid_scanner`

## Requirements
- R1: A frame lasts (N+1) slots of 16 sub-steps of STEP_CYC cycles each, where N is the grid count. `frame_end` is high for exactly one cycle, the last cycle of the key-scan slot, and the next cycle starts slot 0.
- R2: Mode code m (0 to 3) selects N = 4+m grids. Grid k (1-based) is the only lit grid during slot k-1 while the display is on. No grid is lit in the key-scan slot.
- R3: `grid_pins[3:0]` are grids 1 to 4 and `seg_pins[9:0]` are segments 1 to 10. `dual_pins[0]` is grid 7 when N=7 and segment 11 otherwise. `dual_pins[1]` is grid 6 when N>=6 and segment 12 otherwise. `dual_pins[2]` is grid 5 when N>=5 and segment 13 otherwise.
- R4: The RAM byte at address 2(k-1) supplies segments 1 to 8 of digit k from bits 0 to 7. The byte at address 2k-1 supplies segments 9 to 13 from bits 0 to 4. The read port is combinational: `rd_data` answers the `rd_addr` of the same cycle.
- R5: Dimming code d lights the segments for w sub-steps, with w = 1, 2, 4, 10, 11, 12, 13, 14 for d = 0 to 7. The lit sub-steps are 1 to w of each display slot.
- R6: Sub-steps 0 and 15 of every slot have all segments dark, so no segment is lit in the cycle before the grid enable moves to the next digit.
- R7: While `disp_on` is low, every grid, shared and segment output is low in that same cycle. The slot timing and `frame_end` keep running.
- R8: Mode and dimming are sampled only in the `frame_end` cycle. A change in the middle of a frame has no effect until the next frame.
- R9: Reset puts the block in 7-grid mode with dimming code 0, at the first cycle of slot 0. During reset all segment outputs and `frame_end` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Grid-count code (4+code grids) |
| disp_on | input | 1 | Display enable, acts at once |
| dim_sel | input | 3 | Dimming code |
| rd_addr | output | 4 | Display RAM read address |
| rd_data | input | 8 | Display RAM read data, same cycle |
| grid_pins | output | 4 | Grid 1 to 4 enables |
| dual_pins | output | 3 | Shared segment 11-13 / grid 7-5 pins |
| seg_pins | output | 10 | Segment 1 to 10 enables |
| frame_end | output | 1 | One-cycle pulse at end of frame |

## Verification
A wrong sub-step or slot counter shows at the ports within one slot: the lit window falls on the wrong cycles, or the grid moves early. A wrong slot limit moves the `frame_end` pulse, so the error is seen by the end of the first frame. A bad fetch register or a wrong pin-role mapping puts wrong bits on the segment or shared pins from sub-step 1 of the slot where it occurs. A mode or dimming latch that updates too early changes the pattern inside the frame that should still use the old setting.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;
  localparam int SUB_STEPS   = 16;
  localparam int MAX_GRIDS   = 7;
  localparam int SEG_COUNT   = 13;
  localparam int DUAL_PINS   = 3;
  localparam int FIXED_GRIDS = MAX_GRIDS - DUAL_PINS;
  localparam int FIXED_SEGS  = SEG_COUNT - DUAL_PINS;
  localparam int STEP_W      = $clog2(SUB_STEPS);
  localparam int SLOT_W      = $clog2(MAX_GRIDS + 1);

  typedef logic [1:0] mode_t;
  typedef logic [2:0] dim_t;

  // lit sub-steps per slot for each dimming code
  function automatic logic [STEP_W-1:0] pulse_width(dim_t d);
    logic [STEP_W-1:0] w;
    case (d)
      3'd0:    w = STEP_W'(1);
      3'd1:    w = STEP_W'(2);
      3'd2:    w = STEP_W'(4);
      default: w = STEP_W'(32'(d) + 7);
    endcase
    return w;
  endfunction

  // number of display slots selected by a mode code
  function automatic logic [SLOT_W-1:0] grid_count(mode_t m);
    return SLOT_W'(FIXED_GRIDS) + SLOT_W'(m);
  endfunction
endpackage

// File: rtl/scan_timer.sv
module scan_timer
  import ledscan_pkg::*;
#(
  parameter int STEP_CYC = 4,
  localparam int TW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] n_grids,
  output logic [TW-1:0]     tick_q,
  output logic [STEP_W-1:0] step_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic              slot_last,
  output logic              frame_end
);
  logic tick_last, step_last;

  assign tick_last = (tick_q == TW'(STEP_CYC - 1));
  assign step_last = (step_q == STEP_W'(SUB_STEPS - 1));
  assign slot_last = tick_last && step_last;
  assign frame_end = slot_last && (slot_q >= n_grids);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      step_q <= '0;
      slot_q <= '0;
    end else begin
      tick_q <= tick_last ? '0 : tick_q + TW'(1);
      if (tick_last)
        step_q <= step_last ? '0 : step_q + STEP_W'(1);
      if (slot_last)
        slot_q <= frame_end ? '0 : slot_q + SLOT_W'(1);
    end
  end

  // R1: a frame end is followed by the very first cycle of slot 0
  p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (slot_q == '0 && step_q == '0 && tick_q == '0));

  // R1: the slot index never passes the key-scan slot
  p_slot_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= n_grids);
endmodule

// File: rtl/pulse_gate.sv
module pulse_gate
  import ledscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [STEP_W-1:0] step_q,
  input  dim_t              dim,
  output logic              seg_win
);
  logic [STEP_W-1:0] width;

  assign width   = pulse_width(dim);
  assign seg_win = enable && (step_q != '0) && (step_q <= width);

  // R6: the first and last sub-step of a slot are always dark
  p_blank_edges_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == '0 || step_q == STEP_W'(SUB_STEPS - 1)) |-> !seg_win);
endmodule

// File: rtl/pin_mapper.sv
module pin_mapper
  import ledscan_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  mode_t                 mode,
  input  logic [MAX_GRIDS-1:0]  grid_vec,
  input  logic [SEG_COUNT-1:0]  seg_vec,
  output logic [FIXED_GRIDS-1:0] grid_pins,
  output logic [DUAL_PINS-1:0]  dual_pins,
  output logic [FIXED_SEGS-1:0] seg_pins
);
  logic [DUAL_PINS-1:0] grid_role;

  assign grid_pins = grid_vec[FIXED_GRIDS-1:0];
  assign seg_pins  = seg_vec[FIXED_SEGS-1:0];

  for (genvar i = 0; i < DUAL_PINS; i++) begin : g_dual
    localparam int GI = MAX_GRIDS - 1 - i;
    localparam int SI = FIXED_SEGS + i;
    localparam int TH = DUAL_PINS - i;
    assign grid_role[i] = (32'(mode) >= TH);
    assign dual_pins[i] = grid_role[i] ? grid_vec[GI] : seg_vec[SI];
  end

  // R2: at most one pin acting as a grid is lit at any time
  p_single_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grid_pins, dual_pins & grid_role}));
endmodule

// File: rtl/led_grid_scanner.sv
module led_grid_scanner
  import ledscan_pkg::*;
#(
  parameter int STEP_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_sel,
  input  logic        disp_on,
  input  logic [2:0]  dim_sel,
  output logic [3:0]  rd_addr,
  input  logic [7:0]  rd_data,
  output logic [3:0]  grid_pins,
  output logic [2:0]  dual_pins,
  output logic [9:0]  seg_pins,
  output logic        frame_end
);
  localparam int TW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  mode_t             cur_mode;
  dim_t              cur_dim;
  logic [SLOT_W-1:0] n_grids;
  logic [TW-1:0]     tick_q;
  logic [STEP_W-1:0] step_q;
  logic [SLOT_W-1:0] slot_q;
  logic              slot_last;
  logic              disp_slot, lit_slot, seg_win;
  logic              fetch_lo, fetch_hi;
  logic [7:0]        lower_q;
  logic [SEG_COUNT-9:0] upper_q;
  logic [SEG_COUNT-1:0] seg_vec;
  logic [MAX_GRIDS-1:0] grid_vec;

  assign n_grids   = grid_count(cur_mode);
  assign disp_slot = (slot_q < n_grids);
  assign lit_slot  = disp_on && disp_slot;

  // settings are adopted only at the frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mode <= 2'b11;
      cur_dim  <= '0;
    end else if (frame_end) begin
      cur_mode <= mode_sel;
      cur_dim  <= dim_sel;
    end
  end

  scan_timer #(.STEP_CYC(STEP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .n_grids(n_grids),
    .tick_q(tick_q), .step_q(step_q), .slot_q(slot_q),
    .slot_last(slot_last), .frame_end(frame_end)
  );

  // two reads in the blank first sub-step: lower byte, then upper byte
  assign fetch_lo = disp_slot && (step_q == '0) && (tick_q == TW'(0));
  assign fetch_hi = disp_slot && (step_q == '0) && (tick_q == TW'(1));
  assign rd_addr  = disp_slot ? {slot_q[2:0], (tick_q != TW'(0))} : 4'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lower_q <= '0;
      upper_q <= '0;
    end else begin
      if (fetch_lo) lower_q <= rd_data;
      if (fetch_hi) upper_q <= rd_data[SEG_COUNT-9:0];
    end
  end

  pulse_gate u_gate (
    .clk(clk), .rst_n(rst_n), .enable(lit_slot),
    .step_q(step_q), .dim(cur_dim), .seg_win(seg_win)
  );

  assign seg_vec  = seg_win ? {upper_q, lower_q} : '0;
  assign grid_vec = lit_slot ? (MAX_GRIDS'(1) << slot_q) : '0;

  pin_mapper u_map (
    .clk(clk), .rst_n(rst_n), .mode(cur_mode),
    .grid_vec(grid_vec), .seg_vec(seg_vec),
    .grid_pins(grid_pins), .dual_pins(dual_pins), .seg_pins(seg_pins)
  );

  // R7: display off darkens every driven pin in the same cycle
  p_dark_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (grid_pins == '0 && dual_pins == '0 && seg_pins == '0));

  // R8: settings only move in the cycle after a frame end
  p_settings_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end) |-> ($stable(cur_mode) && $stable(cur_dim)));

  // R6: when the grid moves to another digit, the segments were dark just before
  p_blank_before_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grid_vec != $past(grid_vec) && $past(grid_vec) != '0 && grid_vec != '0)
      |-> ($past(seg_vec) == '0));

  // R4: a fetch of the upper byte always follows a lower-byte fetch
  p_fetch_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hi |-> $past(fetch_lo));
endmodule

// File: tb/tb_led_grid_scanner.sv
module tb_led_grid_scanner;
  localparam int STEP_CYC = 4;
  localparam int SLOT_CYC = 16 * STEP_CYC;
  localparam int WIDTHS [8] = '{1, 2, 4, 10, 11, 12, 13, 14};

  typedef struct packed {
    logic [1:0] m;
    logic [2:0] d;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 3'd7, 8'hA5}, '{2'd1, 3'd6, 8'h3C},
    '{2'd2, 3'd5, 8'hFF}, '{2'd3, 3'd4, 8'h81},
    '{2'd0, 3'd3, 8'h5A}, '{2'd1, 3'd2, 8'hC3},
    '{2'd2, 3'd1, 8'h0F}, '{2'd3, 3'd0, 8'hE7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = '0;
  logic disp_on = 1'b0;
  logic [2:0] dim_sel = '0;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;
  logic [3:0] grid_pins;
  logic [2:0] dual_pins;
  logic [9:0] seg_pins;
  logic frame_end;
  logic [7:0] ram [16];

  int checks = 0;
  int fails = 0;

  assign rd_data = ram[rd_addr];

  always #10 clk = ~clk;

  led_grid_scanner #(.STEP_CYC(STEP_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .disp_on(disp_on),
    .dim_sel(dim_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .grid_pins(grid_pins), .dual_pins(dual_pins), .seg_pins(seg_pins),
    .frame_end(frame_end)
  );

  function automatic int grids_for(int m);
    case (m)
      0: return 4;
      1: return 5;
      2: return 6;
      default: return 7;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill_ram(logic [7:0] seed);
    for (int i = 0; i < 16; i++) ram[i] = seed ^ 8'(i * 29);
  endtask

  task automatic wait_frame_end();
    do @(negedge clk); while (frame_end !== 1'b1);
  endtask

  // checks one whole frame, cycle by cycle, from a bench-side model
  task automatic run_frame(int n, int w, bit on, string req);
    int len = (n + 1) * SLOT_CYC;
    int bad = 0;
    int fe_bad = 0;
    logic [16:0] first_act = '0;
    logic [16:0] first_exp = '0;
    for (int c = 0; c < len; c++) begin
      int slot = c / SLOT_CYC;
      int step = (c / STEP_CYC) % 16;
      bit shown = on && (slot < n);
      bit lit = shown && (step >= 1) && (step <= w);
      logic [6:0] g = '0;
      logic [12:0] s = '0;
      logic [16:0] exp_pins;
      logic [16:0] act_pins;
      @(negedge clk);
      if (shown) g[slot] = 1'b1;
      if (lit)
        for (int k = 0; k < 13; k++)
          s[k] = (k < 8) ? ram[2 * slot][k] : ram[2 * slot + 1][k - 8];
      exp_pins = {g[3:0],
                  (n >= 5) ? g[4] : s[12],
                  (n >= 6) ? g[5] : s[11],
                  (n == 7) ? g[6] : s[10],
                  s[9:0]};
      act_pins = {grid_pins, dual_pins, seg_pins};
      if (act_pins !== exp_pins) begin
        if (bad == 0) begin
          first_act = act_pins;
          first_exp = exp_pins;
        end
        bad++;
      end
      if (frame_end !== (c == len - 1)) fe_bad++;
    end
    check(bad == 0, req, "pin pattern over frame", int'(first_act), int'(first_exp));
    check(fe_bad == 0, "R1", "frame_end misplaced cycles", fe_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R9: reset state, with inputs that differ from the power-on settings
    fill_ram(8'h96);
    mode_sel = 2'd0;
    dim_sel = 3'd5;
    repeat (3) @(negedge clk);
    check({grid_pins, dual_pins, seg_pins, frame_end} == '0, "R9",
          "outputs during reset", int'({grid_pins, dual_pins, seg_pins, frame_end}), 0);
    disp_on = 1'b1;
    @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: first frame runs 7 grids at width 1 regardless of the inputs
    run_frame(7, 1, 1'b1, "R9");

    // main table: modes, dimming codes and RAM patterns (R2 R3 R4 R5)
    for (int i = 0; i < 8; i++) begin
      mode_sel = VECS[i].m;
      dim_sel = VECS[i].d;
      fill_ram(VECS[i].seed);
      wait_frame_end();
      run_frame(grids_for(int'(VECS[i].m)), WIDTHS[VECS[i].d], 1'b1, "R2 R3 R4 R5 R6");
    end

    // R7: display off, timing keeps going
    disp_on = 1'b0;
    run_frame(7, WIDTHS[0], 1'b0, "R7");
    disp_on = 1'b1;

    // R8: settings changed mid-frame wait for the frame boundary
    mode_sel = 2'd1;
    dim_sel = 3'd3;
    fill_ram(8'h6B);
    wait_frame_end();
    fork
      run_frame(5, WIDTHS[3], 1'b1, "R8");
      begin
        repeat (200) @(negedge clk);
        mode_sel = 2'd3;
        dim_sel = 3'd7;
      end
    join
    run_frame(7, WIDTHS[7], 1'b1, "R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule